// File: doc/BRIEF.md
# Serial Register-Access Master for a Data Converter

This block lets on-chip logic read and write the configuration registers of an external data converter over a four-wire serial bus. A request arrives on a valid/ready handshake and carries a read/write flag, an 8-bit register address and, for writes, an 8-bit value. The block turns each request into 24-bit frames of command byte, address byte and data byte, sent most significant bit first. It drives chip select, serial clock and serial data out, and samples serial data in.

The converter does not return read data in the frame that carries the read command. A read is therefore a two-frame transaction. The block sends the read command frame, waits one idle bit period, and then sends an all-zero filler frame on its own. The first eight bits sampled during the filler frame are the register value. That value appears on `rd_data` together with a one-cycle `rd_done` pulse. A write is a single frame and also ends with an `rd_done` pulse.

The controller has four states. ST_IDLE accepts a request and goes to ST_FRAME. ST_FRAME shifts 24 bits and then goes to ST_GUARD. ST_GUARD holds chip select high for one bit period. From there it goes back to ST_FRAME for the filler frame of a read, or on to ST_DONE. ST_DONE lasts one cycle and returns to ST_IDLE.

Top module: `regbus_spi_master`

## Requirements
- R1: A write request produces one frame whose bits, most significant first, are command byte 0x08, then the address byte, then the write data byte.
- R2: A read request produces a frame of 0x10, the address byte and 0x00, followed automatically by a second frame of 24 zero bits.
- R3: After a read, `rd_data` holds the first 8 bits sampled in the second frame, with the first sampled bit in bit 7. The value is valid in the cycle `rd_done` is high and is kept unchanged until the next read completes, including across writes.
- R4: The bus uses mode 0. The serial clock is low whenever chip select is high. In each bit period the serial clock is low for the first floor(d/2)+1 system cycles and high for the rest, where d is the effective divider. Serial data out changes only while the serial clock is low, and the first bit is valid from the cycle chip select falls.
- R5: Chip select is low for exactly 24 bit periods per frame. After every frame it is high for exactly one bit period: between the two frames of a read, and before completion.
- R6: A bit period lasts d+1 system clock cycles, where d is `clk_div` sampled when the request is accepted. A value of 0 is treated as 1. Changes to `clk_div` during a transaction have no effect on it.
- R7: `rd_done` is high for exactly one cycle, in the cycle after the final idle bit period. `req_ready` is high again in the next cycle.
- R8: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until completion, and requests presented in that time are ignored and never reach the bus.
- R9: A synchronous reset sets chip select high, the serial clock low, serial data out low, `req_ready` high, `rd_done` low and `rd_data` to 0.
- R10: Serial data in is sampled on the last system clock cycle of each bit period, while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_is_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write value (ignored for reads) |
| clk_div | input | DIV_W | Bit-period divider d; bit period is d+1 clocks |
| rd_data | output | 8 | Last register value read |
| rd_done | output | 1 | One-cycle pulse at transaction end |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
A wrong controller state shows at the pins within one system cycle. A stray frame or guard state moves the chip-select edges, a lost filler frame ends a read 25 bit periods early, and a stuck state holds `req_ready` low. The bench compares chip select, serial clock, data out, ready and done against its reference on every cycle, so such a fault is caught in the first cycle it affects. A fault in the bit counter or phase counter moves a clock edge or a data bit, which is seen at that bit. A wrong capture point only shows as a wrong `rd_data` value when the read completes, which the bench checks against a modelled register file in the converter.

// File: rtl/rspi_pkg.sv
package rspi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GUARD,
        ST_DONE
    } rspi_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h08;
    localparam logic [BYTE_W-1:0] CMD_READ  = 8'h10;
endpackage

// File: rtl/rspi_bit_timer.sv
module rspi_bit_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             clk_high,
    output logic             period_end
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    assign half       = div >> 1;
    assign clk_high   = run && (cnt_q > half);
    assign period_end = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the phase counter never passes the latched divider
    a_r6_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/rspi_frame_shift.sv
module rspi_frame_shift #(
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned CAP_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               advance,
    input  logic               miso,
    output logic               mosi_bit,
    output logic               bit_last,
    output logic [CAP_W-1:0]   cap_head
);
    localparam int unsigned CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic [CNT_W-1:0]   idx_q;

    assign mosi_bit = tx_q[FRAME_W-1];
    assign bit_last = (idx_q == LAST_IDX);
    assign cap_head = rx_q[FRAME_W-1 -: CAP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            tx_q  <= load_word;
            idx_q <= '0;
        end else if (advance) begin
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
            rx_q  <= {rx_q[FRAME_W-2:0], miso};
            idx_q <= bit_last ? '0 : idx_q + 1'b1;
        end
    end

    // R5: the bit index stays inside one frame
    a_r5_index_in_frame: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX);
endmodule

// File: rtl/regbus_spi_master.sv
module regbus_spi_master
    import rspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_read,
    input  logic [7:0]       req_addr,
    input  logic [7:0]       req_wdata,
    input  logic [DIV_W-1:0] clk_div,
    output logic [7:0]       rd_data,
    output logic             rd_done,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int unsigned FRAME_W = 3 * BYTE_W;

    rspi_state_e state_q, state_d;

    logic             is_read_q;
    logic             second_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       rd_data_q;

    logic               timer_run, clk_high, period_end;
    logic               accept, load_nop, load_any, advance, frame_end;
    logic               mosi_bit, bit_last;
    logic [7:0]         cap_head;
    logic [FRAME_W-1:0] load_word;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign load_nop  = (state_q == ST_GUARD) && period_end && is_read_q && !second_q;
    assign load_any  = accept || load_nop;
    assign advance   = (state_q == ST_FRAME) && period_end;
    assign frame_end = advance && bit_last;
    assign timer_run = (state_q == ST_FRAME) || (state_q == ST_GUARD);
    assign load_word = accept ? {(req_is_read ? CMD_READ : CMD_WRITE), req_addr,
                                 (req_is_read ? 8'h00 : req_wdata)}
                              : '0;

    rspi_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (timer_run),
        .div        (div_q),
        .clk_high   (clk_high),
        .period_end (period_end)
    );

    rspi_frame_shift #(.FRAME_W(FRAME_W), .CAP_W(8)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load_any),
        .load_word (load_word),
        .advance   (advance),
        .miso      (spi_miso),
        .mosi_bit  (mosi_bit),
        .bit_last  (bit_last),
        .cap_head  (cap_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_FRAME;
            ST_FRAME: if (frame_end) state_d = ST_GUARD;
            ST_GUARD: if (period_end)
                          state_d = (is_read_q && !second_q) ? ST_FRAME : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_read_q <= 1'b0;
            second_q  <= 1'b0;
            div_q     <= DIV_W'(1);
            rd_data_q <= '0;
        end else begin
            if (accept) begin
                is_read_q <= req_is_read;
                second_q  <= 1'b0;
                div_q     <= (clk_div == '0) ? DIV_W'(1) : clk_div;
            end
            if (load_nop) begin
                second_q <= 1'b1;
            end
            if ((state_q == ST_GUARD) && period_end && is_read_q && second_q) begin
                rd_data_q <= cap_head;
            end
        end
    end

    always_comb begin
        spi_cs_n  = 1'b1;
        spi_sclk  = 1'b0;
        spi_mosi  = 1'b0;
        req_ready = 1'b0;
        rd_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FRAME: begin
                spi_cs_n = 1'b0;
                spi_sclk = clk_high;
                spi_mosi = mosi_bit;
            end
            ST_GUARD: ;
            ST_DONE:  rd_done = 1'b1;
            default:  ;
        endcase
    end

    assign rd_data = rd_data_q;

    // R4: clock idles low while deselected
    a_r4_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);
    // R4: data out only moves while the clock is low
    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_mosi));
    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);
    // R7: ready follows completion
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> req_ready);
    // R8: never ready while the bus is selected
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);
    // R5: a frame always ends into a deselected bit period
    a_r5_guard_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> !rd_done);
endmodule

// File: tb/regbus_spi_master_tb.sv
module regbus_spi_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_is_read = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] clk_div = 8'd1;
    logic       req_ready, rd_done, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    regbus_spi_master #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_read(req_is_read), .req_addr(req_addr), .req_wdata(req_wdata),
        .clk_div(clk_div), .rd_data(rd_data), .rd_done(rd_done),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // converter model: register file, answers a read in the following frame
    logic [7:0]  dev_mem [256];
    logic [23:0] dev_in, dev_out;
    logic [7:0]  dev_pend;
    bit          dev_pend_v = 0;
    int          dev_idx;

    initial for (int i = 0; i < 256; i++) dev_mem[i] = 8'(i) ^ 8'h3C;

    always @(negedge spi_cs_n) begin
        dev_out    = dev_pend_v ? {dev_pend, 16'h0} : 24'h5A3C96;
        dev_pend_v = 0;
        dev_idx    = 0;
        dev_in     = '0;
        spi_miso   = dev_out[23];
    end
    always @(posedge spi_sclk) if (!spi_cs_n) dev_in = {dev_in[22:0], spi_mosi};
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        dev_idx++;
        if (dev_idx < 24) spi_miso = dev_out[23 - dev_idx];
    end
    always @(posedge spi_cs_n) begin
        if (dev_in[23:16] == 8'h08) dev_mem[dev_in[15:8]] = dev_in[7:0];
        else if (dev_in[23:16] == 8'h10) begin
            dev_pend   = dev_mem[dev_in[15:8]];
            dev_pend_v = 1;
        end
    end

    // bench reference of register contents and last read value
    logic [7:0] ref_mem [256];
    logic [7:0] ref_rd = 8'h00;
    initial for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h3C;

    task automatic check(input bit ok, input string tag, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, detail);
        end
    endtask

    task automatic step(input bit e_cs, input bit e_sck, input bit e_mo,
                        input bit e_rdy, input bit e_done, input string tag,
                        input bit noise, inout int cyc);
        @(negedge clk);
        check({spi_cs_n, spi_sclk, spi_mosi, req_ready, rd_done} ==
              {e_cs, e_sck, e_mo, e_rdy, e_done}, tag,
              $sformatf("cyc %0d cs/sclk/mosi/rdy/done actual %b%b%b%b%b expected %b%b%b%b%b",
                        cyc, spi_cs_n, spi_sclk, spi_mosi, req_ready, rd_done,
                        e_cs, e_sck, e_mo, e_rdy, e_done));
        if (noise && cyc == 0) begin
            // R8: foreign request and divider change during a busy transaction
            req_valid = 1; req_is_read = 0; req_addr = 8'hEE; req_wdata = 8'h11;
            clk_div = 8'd0;
        end
        if ((!noise && cyc == 0) || (noise && cyc == 6)) req_valid = 0;
        cyc++;
    endtask

    task automatic run_txn(input bit rd, input logic [7:0] a, input logic [7:0] d,
                           input int dv, input bit noise);
        int de;
        int cyc;
        logic [23:0] w;
        string ftag;
        de = (dv == 0) ? 1 : dv;
        @(negedge clk);
        req_valid = 1; req_is_read = rd; req_addr = a; req_wdata = d;
        clk_div = 8'(dv);
        @(posedge clk);
        cyc = 0;
        ftag = rd ? "R2 R4 R5 R6" : "R1 R4 R5 R6";
        if (noise) ftag = {ftag, " R8"};
        for (int f = 0; f < (rd ? 2 : 1); f++) begin
            w = (f == 1) ? 24'h0 : (rd ? {8'h10, a, 8'h00} : {8'h08, a, d});
            for (int b = 0; b < 24; b++)
                for (int k = 0; k <= de; k++)
                    step(1'b0, k > de / 2, w[23 - b], 1'b0, 1'b0, ftag, noise, cyc);
            for (int k = 0; k <= de; k++)
                step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 guard", noise, cyc);
        end
        if (rd) ref_rd = ref_mem[a];
        else    ref_mem[a] = d;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7 done", noise, cyc);
        check(rd_data == ref_rd, "R3 R10 rd_data",
              $sformatf("actual %h expected %h", rd_data, ref_rd));
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 R8 ready", noise, cyc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check({spi_cs_n, spi_sclk, spi_mosi, req_ready, rd_done} == 5'b10010 && rd_data == 8'h00,
              "R9 reset", $sformatf("actual %b%b%b%b%b/%h expected 10010/00",
              spi_cs_n, spi_sclk, spi_mosi, req_ready, rd_done, rd_data));

        run_txn(0, 8'h1F, 8'hC3, 1, 0);   // R1 write, divider 1
        run_txn(1, 8'h1F, 8'h00, 1, 0);   // R2 R3 read back
        run_txn(1, 8'h40, 8'h77, 3, 0);   // R3 R6 read of untouched register, divider 3
        run_txn(0, 8'h05, 8'hA6, 4, 0);   // R1 R3 write keeps rd_data, divider 4
        run_txn(1, 8'h05, 8'h00, 2, 0);   // R6 even divider
        run_txn(0, 8'h81, 8'h3E, 0, 0);   // R6 divider 0 behaves as 1
        run_txn(1, 8'h81, 8'h00, 0, 0);
        run_txn(1, 8'h22, 8'h00, 2, 1);   // R8 requests ignored while busy
        run_txn(1, 8'hEE, 8'h00, 1, 0);   // R8 ignored write never reached the register
        run_txn(0, 8'hFF, 8'h00, 5, 1);   // R6 divider change mid-transaction ignored
        run_txn(1, 8'hEE, 8'h00, 1, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule